// File: doc/BRIEF.md
# Ethernet Pause-Frame Transmit Throttle

This block watches the byte stream coming in on the receive side of a full-duplex Ethernet MAC and picks out MAC control pause frames. When a good pause frame arrives, and both the link and the flow-control configuration allow it, the block holds off the transmit side. The hold lasts for the number of quanta the frame asks for. One quantum is 512 bit times, which the block counts as a fixed number of MAC clock cycles (128 by default).

The hold never cuts a transmission short. The request waits until the transmit side reports that it is idle, and only then does the hold begin. For every received frame the block also gives a keep-or-discard verdict. Recognised pause frames are discarded unless the pass-all configuration bit is set. All other frames are kept.

The receive stream uses these conventions:
- `rx_sof` is asserted together with the `rx_valid` of the first byte.
- `rx_eof` is a one-cycle strobe in a cycle that carries no data. `rx_good` qualifies that strobe.

Top module: `pause_throttle`

## Requirements
- R1: A frame is a pause frame only when all of the following hold:
  - byte positions 0..5 are 01 80 C2 00 00 01;
  - positions 12..13 are 88 08;
  - positions 14..15 are 00 01;
  - at least 18 bytes arrived;
  - `rx_good` is 1 at `rx_eof`.
  The source address bytes (positions 6..11) have no influence on recognition.
- R2: One cycle after each `rx_eof`, `rx_verdict_valid` pulses for one cycle. In that cycle `rx_forward` is 0 for a recognised pause frame when `cfg_pass_all` is 0, and 1 in every other case.
- R3: The pause value is bytes 16 (high) and 17 (low), taken in network order. An accepted value N > 0 holds `tx_hold` high for exactly N × 128 consecutive cycles.
- R4: While `cfg_rx_fc_en` is 0 at the end of a frame, that pause frame causes no hold.
- R5: While `cfg_full_duplex` is 0 at the end of a frame, that pause frame causes no hold.
- R6: While `tx_busy` is 1, an accepted pause request waits. `tx_hold` rises on the first cycle after an edge at which `tx_busy` is sampled 0.
- R7: A pause frame accepted during an active hold reloads the count with its own value. A value of 0 ends the hold.
- R8: A synchronous active-high `rst` clears the hold, any pending request, the parser and the verdict outputs.
- R9: A frame that fails R1, whether from a wrong checked byte, a bad-frame end, or being too short, causes no hold and is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full_duplex | input | 1 | 1 when the link runs full duplex |
| cfg_rx_fc_en | input | 1 | Enables acting on received pause frames |
| cfg_pass_all | input | 1 | Keep recognised pause frames instead of discarding them |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_eof | input | 1 | End-of-frame strobe, no data in that cycle |
| rx_good | input | 1 | Frame judged good, sampled with rx_eof |
| tx_busy | input | 1 | Transmit side is in the middle of a frame |
| tx_hold | output | 1 | Hold off new transmissions |
| rx_verdict_valid | output | 1 | Verdict for the frame just ended |
| rx_forward | output | 1 | 1 = keep the frame, 0 = discard it |

## Verification
Each internal fault shows up at the ports in a predictable way:
- A parser whose byte position or match flag goes wrong shows it one cycle after the end strobe, as a wrong verdict and a hold that is missing or not expected.
- A quantum prescaler or quanta counter that slips by even one count changes the length of the hold. The bench therefore measures every hold to the exact cycle, as a multiple of 128.
- A pending-request register that loads early or is lost shows as `tx_hold` rising while `tx_busy` is high, or never rising, on the first cycle after the transmitter goes idle.

// File: rtl/pause_pkg.sv
package pause_pkg;

   localparam int PAUSE_VAL_W   = 16;
   localparam int POS_TIMER_HI  = 16;
   localparam int POS_TIMER_LO  = 17;
   localparam int MIN_FRAME_LEN = 18;

   typedef struct packed {
      logic                   valid;
      logic [PAUSE_VAL_W-1:0] quanta;
   } pause_req_t;

   // {care, value} for each checked byte position of a pause frame
   function automatic logic [8:0] ref_byte(input int unsigned pos);
      case (pos)
         0:       ref_byte = {1'b1, 8'h01};
         1:       ref_byte = {1'b1, 8'h80};
         2:       ref_byte = {1'b1, 8'hC2};
         3:       ref_byte = {1'b1, 8'h00};
         4:       ref_byte = {1'b1, 8'h00};
         5:       ref_byte = {1'b1, 8'h01};
         12:      ref_byte = {1'b1, 8'h88};
         13:      ref_byte = {1'b1, 8'h08};
         14:      ref_byte = {1'b1, 8'h00};
         15:      ref_byte = {1'b1, 8'h01};
         default: ref_byte = {1'b0, 8'h00};
      endcase
   endfunction

endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
   import pause_pkg::*;
#(
   parameter int POS_W = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cfg_pass_all,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_sof,
   input  logic       rx_eof,
   input  logic       rx_good,
   output pause_req_t req,
   output logic       verdict_valid,
   output logic       forward
);

   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] POS_MIN = POS_W'(MIN_FRAME_LEN);

   logic [POS_W-1:0]       cnt;
   logic [POS_W-1:0]       pos;
   logic [POS_W-1:0]       pos_next;
   logic                   match;
   logic                   byte_ok;
   logic [8:0]             ref_b;
   logic [PAUSE_VAL_W-1:0] timer_q;
   logic                   recognised;

   assign pos      = rx_sof ? '0 : cnt;
   assign pos_next = (pos == POS_MAX) ? pos : pos + POS_W'(1);
   assign ref_b    = ref_byte(int'(pos));
   assign byte_ok  = !ref_b[8] || (rx_data == ref_b[7:0]);

   assign recognised = rx_eof && rx_good && match && (cnt >= POS_MIN);
   assign req.valid  = recognised;
   assign req.quanta = timer_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt           <= '0;
         match         <= 1'b0;
         timer_q       <= '0;
         verdict_valid <= 1'b0;
         forward       <= 1'b0;
      end else begin
         verdict_valid <= rx_eof;
         if (rx_eof) begin
            forward <= !recognised || cfg_pass_all;
         end
         if (rx_valid) begin
            cnt   <= pos_next;
            match <= (rx_sof ? 1'b1 : match) && byte_ok;
            if (int'(pos) == POS_TIMER_HI) timer_q[15:8] <= rx_data;
            if (int'(pos) == POS_TIMER_LO) timer_q[7:0]  <= rx_data;
         end
         if (rx_eof) begin
            cnt   <= '0;
            match <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pause_request_latch.sv
module pause_request_latch
   import pause_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   accept,
   input  logic [PAUSE_VAL_W-1:0] accept_quanta,
   input  logic                   tx_busy,
   output logic                   load,
   output logic [PAUSE_VAL_W-1:0] load_quanta
);

   logic pend;

   assign load = pend && !tx_busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend        <= 1'b0;
         load_quanta <= '0;
      end else if (accept) begin
         pend        <= 1'b1;
         load_quanta <= accept_quanta;
      end else if (load) begin
         pend        <= 1'b0;
      end
   end

endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
   import pause_pkg::*;
#(
   parameter int QUANTUM_CLKS = 128
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic [PAUSE_VAL_W-1:0] load_quanta,
   output logic                   hold
);

   localparam int PRE_W = $clog2(QUANTUM_CLKS);

   logic [PRE_W-1:0]       pre;
   logic [PAUSE_VAL_W-1:0] quanta;
   logic                   tick;

   generate
      if ((QUANTUM_CLKS & (QUANTUM_CLKS - 1)) == 0) begin : g_pow2
         assign tick = &pre;
      end else begin : g_cmp
         assign tick = (pre == PRE_W'(QUANTUM_CLKS - 1));
      end
   endgenerate

   assign hold = (quanta != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         quanta <= '0;
         pre    <= '0;
      end else if (load) begin
         quanta <= load_quanta;
         pre    <= '0;
      end else if (hold) begin
         if (tick) begin
            pre    <= '0;
            quanta <= quanta - PAUSE_VAL_W'(1);
         end else begin
            pre    <= pre + PRE_W'(1);
         end
      end
   end

endmodule

// File: rtl/pause_throttle.sv
module pause_throttle
   import pause_pkg::*;
#(
   parameter int QUANTUM_CLKS = 128,
   parameter int POS_W        = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cfg_full_duplex,
   input  logic       cfg_rx_fc_en,
   input  logic       cfg_pass_all,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_sof,
   input  logic       rx_eof,
   input  logic       rx_good,
   input  logic       tx_busy,
   output logic       tx_hold,
   output logic       rx_verdict_valid,
   output logic       rx_forward
);

   generate
      if (QUANTUM_CLKS < 2) begin : g_bad_quantum
         $error("QUANTUM_CLKS must be at least 2");
      end
      if ((1 << POS_W) <= MIN_FRAME_LEN) begin : g_bad_pos
         $error("POS_W too narrow to reach the pause field");
      end
   endgenerate

   pause_req_t             req;
   logic                   accept;
   logic                   load;
   logic [PAUSE_VAL_W-1:0] load_quanta;

   assign accept = req.valid && cfg_rx_fc_en && cfg_full_duplex;

   pause_frame_parser #(.POS_W(POS_W)) u_parser (
      .clk           (clk),
      .rst           (rst),
      .cfg_pass_all  (cfg_pass_all),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .rx_sof        (rx_sof),
      .rx_eof        (rx_eof),
      .rx_good       (rx_good),
      .req           (req),
      .verdict_valid (rx_verdict_valid),
      .forward       (rx_forward)
   );

   pause_request_latch u_latch (
      .clk           (clk),
      .rst           (rst),
      .accept        (accept),
      .accept_quanta (req.quanta),
      .tx_busy       (tx_busy),
      .load          (load),
      .load_quanta   (load_quanta)
   );

   pause_quanta_timer #(.QUANTUM_CLKS(QUANTUM_CLKS)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .load_quanta (load_quanta),
      .hold        (tx_hold)
   );

endmodule

// File: rtl/pause_throttle_chk.sv
module pause_throttle_chk (
   input logic clk,
   input logic rst,
   input logic cfg_pass_all,
   input logic rx_eof,
   input logic tx_busy,
   input logic tx_hold,
   input logic rx_verdict_valid,
   input logic rx_forward
);

   p_verdict_follows_eof_r2: assert property (@(posedge clk) disable iff (rst)
      rx_eof |=> rx_verdict_valid);

   p_verdict_needs_eof_r2: assert property (@(posedge clk) disable iff (rst)
      rx_verdict_valid |-> $past(rx_eof));

   p_pass_all_keeps_r2: assert property (@(posedge clk) disable iff (rst)
      (rx_verdict_valid && $past(cfg_pass_all)) |-> rx_forward);

   p_hold_starts_idle_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_hold) |-> !$past(tx_busy));

   p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!tx_hold && !rx_verdict_valid));

endmodule

bind pause_throttle pause_throttle_chk u_chk (
   .clk              (clk),
   .rst              (rst),
   .cfg_pass_all     (cfg_pass_all),
   .rx_eof           (rx_eof),
   .tx_busy          (tx_busy),
   .tx_hold          (tx_hold),
   .rx_verdict_valid (rx_verdict_valid),
   .rx_forward       (rx_forward)
);

// File: tb/pause_throttle_test.sv
`timescale 1ns/1ps
module pause_throttle_test;

   localparam int Q = 128;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_full_duplex = 1'b1;
   logic       cfg_rx_fc_en = 1'b1;
   logic       cfg_pass_all = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_sof = 1'b0;
   logic       rx_eof = 1'b0;
   logic       rx_good = 1'b0;
   logic       tx_busy = 1'b0;
   logic       tx_hold;
   logic       rx_verdict_valid;
   logic       rx_forward;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pause_throttle uut (
      .clk(clk), .rst(rst),
      .cfg_full_duplex(cfg_full_duplex), .cfg_rx_fc_en(cfg_rx_fc_en),
      .cfg_pass_all(cfg_pass_all),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_good(rx_good), .tx_busy(tx_busy),
      .tx_hold(tx_hold), .rx_verdict_valid(rx_verdict_valid),
      .rx_forward(rx_forward)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] frame_byte(input int i, input int n);
      case (i)
         0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
         3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
         6: return 8'h02;  7: return 8'h11;  8: return 8'h22;
         9: return 8'h33; 10: return 8'h44; 11: return 8'h55;
        12: return 8'h88; 13: return 8'h08; 14: return 8'h00;
        15: return 8'h01; 16: return n[15:8]; 17: return n[7:0];
         default: return 8'h00;
      endcase
   endfunction

   // returns at the falling edge just after the end-strobe edge
   task automatic send_frame(input int corrupt, input int n, input bit good,
                             input int len, output bit vv, output bit fwd);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_data  = frame_byte(i, n) ^ ((i == corrupt) ? 8'hFF : 8'h00);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1; rx_good = good;
      @(negedge clk);
      rx_eof = 1'b0; rx_good = 1'b0;
      vv  = rx_verdict_valid;
      fwd = rx_forward;
   endtask

   task automatic measure(output int cnt);
      cnt = 0;
      @(negedge clk);
      while (tx_hold && cnt < 70000) begin
         cnt++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit vv, fwd;
      int cnt;
      int vals[6] = '{0, 1, 2, 3, 7, 256};
      int pos_list[10] = '{0, 1, 2, 3, 4, 5, 12, 13, 14, 15};

      repeat (3) @(negedge clk);
      chk("R8 reset hold", tx_hold, 0);
      chk("R8 reset verdict", rx_verdict_valid, 0);
      rst = 1'b0;
      @(negedge clk);

      // R3: hold length sweep
      foreach (vals[k]) begin
         send_frame(-1, vals[k], 1'b1, 20, vv, fwd);
         chk("R2 verdict pulse", vv, 1);
         chk("R2 pause dropped", fwd, 0);
         measure(cnt);
         chk($sformatf("R3 hold length n=%0d", vals[k]), cnt, vals[k] * Q);
      end

      // R4/R5/R2: configuration sweep
      for (int c = 0; c < 8; c++) begin
         cfg_full_duplex = c[0];
         cfg_rx_fc_en    = c[1];
         cfg_pass_all    = c[2];
         send_frame(-1, 1, 1'b1, 20, vv, fwd);
         chk($sformatf("R2 pass-all forward cfg=%0d", c), fwd, c[2]);
         measure(cnt);
         chk($sformatf("R4 R5 hold cfg=%0d", c), cnt, (c[0] && c[1]) ? Q : 0);
      end
      cfg_full_duplex = 1'b1; cfg_rx_fc_en = 1'b1; cfg_pass_all = 1'b0;

      // R9: each checked byte corrupted
      foreach (pos_list[k]) begin
         send_frame(pos_list[k], 1, 1'b1, 20, vv, fwd);
         chk($sformatf("R9 corrupt pos %0d kept", pos_list[k]), fwd, 1);
         measure(cnt);
         chk($sformatf("R9 corrupt pos %0d no hold", pos_list[k]), cnt, 0);
      end

      // R1: source address does not matter
      send_frame(8, 2, 1'b1, 20, vv, fwd);
      chk("R1 source addr ignored drop", fwd, 0);
      measure(cnt);
      chk("R1 source addr ignored hold", cnt, 2 * Q);

      // R9: bad end and short frame
      send_frame(-1, 1, 1'b0, 20, vv, fwd);
      chk("R9 bad frame kept", fwd, 1);
      measure(cnt);
      chk("R9 bad frame no hold", cnt, 0);
      send_frame(-1, 1, 1'b1, 17, vv, fwd);
      chk("R9 short frame kept", fwd, 1);
      measure(cnt);
      chk("R9 short frame no hold", cnt, 0);
      send_frame(-1, 1, 1'b1, 18, vv, fwd);
      chk("R1 minimum length drop", fwd, 0);
      measure(cnt);
      chk("R1 minimum length hold", cnt, Q);

      // R6: wait for transmitter idle
      tx_busy = 1'b1;
      send_frame(-1, 1, 1'b1, 20, vv, fwd);
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tx_hold) cnt++;
      end
      chk("R6 no hold while busy", cnt, 0);
      tx_busy = 1'b0;
      @(negedge clk);
      chk("R6 hold rises after idle", tx_hold, 1);
      measure(cnt);
      chk("R6 hold length after idle", cnt + 1, Q);

      // R7: reload during hold, then zero cancel
      send_frame(-1, 4, 1'b1, 20, vv, fwd);
      repeat (60) @(negedge clk);
      send_frame(-1, 1, 1'b1, 20, vv, fwd);
      chk("R7 hold active before reload", tx_hold, 1);
      measure(cnt);
      chk("R7 reload length", cnt, Q);
      send_frame(-1, 4, 1'b1, 20, vv, fwd);
      repeat (30) @(negedge clk);
      send_frame(-1, 0, 1'b1, 20, vv, fwd);
      measure(cnt);
      chk("R7 zero ends hold", cnt, 0);

      // R8: reset in the middle of a hold
      send_frame(-1, 2, 1'b1, 20, vv, fwd);
      repeat (40) @(negedge clk);
      chk("R8 hold before reset", tx_hold, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R8 reset clears hold", tx_hold, 0);
      measure(cnt);
      chk("R8 stays clear", cnt, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule